// File: doc/BRIEF.md
# Reset Configuration Word Latch

This block holds the configuration word that a device runs with after reset, when that word arrives from outside rather than being fixed on chip. During power-on reset it looks at the level of an active-low strobe input to choose one of two modes. In the default mode the configuration word stays all zeros. In the external mode, the end of a low pulse on the strobe loads the word present on a 32-bit data bus, but only while hard reset is asserted.

The stored word is cleared only by power-on reset. A hard reset later in operation therefore leaves the device with the word that was loaded, not with the all-zero default. A valid flag shows that at least one word has been loaded since power-on. The strobe and hard reset inputs are asynchronous and pass through two-flop synchronizers before use. Power-on reset is asserted asynchronously and released in step with the clock.

Top module: `cfg_word_latch`

## Requirements
- R1: The level of `strobe_ni` in the last clock cycles before the internal power-on reset releases sets the mode. High selects external loading and drives `cfg_ext_o` to 1. Low selects the default and drives `cfg_ext_o` to 0. The mode is visible from the second rising clock edge after `por_ni` rises and does not change until the next power-on reset.
- R2: In default mode (`cfg_ext_o` = 0), strobe pulses have no effect: `cfg_word_o` stays 32'h0 and `cfg_valid_o` stays 0.
- R3: In external mode, while `hreset_ni` is low, the rising edge that ends a low pulse on `strobe_ni` loads the value on `data_i`. The value appears on `cfg_word_o` after the third rising clock edge following that strobe edge, and not before it. `data_i` must be held from the start of the pulse until then.
- R4: A strobe pulse that ends while `hreset_ni` is high leaves `cfg_word_o` unchanged.
- R5: Power-on reset clears `cfg_word_o` to 32'h0 and `cfg_valid_o` to 0. In external mode with the strobe held high and never pulsed, both keep those values.
- R6: `cfg_valid_o` rises together with the first loaded word and stays 1 until the next power-on reset.
- R7: Every further accepted pulse in the same hard-reset window replaces the stored word with the new bus value.
- R8: Releasing and then asserting `hreset_ni` again keeps the loaded word on `cfg_word_o`. It does not return to 32'h0.
- R9: Each new power-on reset samples the mode again, so the device can switch between the default and external modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous assert |
| hreset_ni | input | 1 | Hard reset, active low, asynchronous; opens the load window |
| strobe_ni | input | 1 | Configuration strobe, active low, asynchronous |
| data_i | input | 32 | Configuration data bus |
| cfg_word_o | output | 32 | Active configuration word |
| cfg_valid_o | output | 1 | A word has been loaded since power-on |
| cfg_ext_o | output | 1 | 1 = external loading mode, 0 = all-zero default |

## Verification
A loaded word is due after the third rising edge that follows the strobe's rising edge. That delay is two synchronizer stages plus the edge-detect and store register. The mode is due two edges after power-on reset releases, and hard reset takes two edges to reach the load window. The bench drives all inputs on falling edges and counts falling edges from each change. For one load it checks that the old word is still present one edge before the new word is due, and then checks the new value on the edge it is due. The main sweep loads walking-one, walking-zero and multiplicative data patterns through the full load path, with each word predicted arithmetically in the bench.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic {
    CFG_DEFAULT  = 1'b0,
    CFG_EXTERNAL = 1'b1
  } cfg_mode_e;
endpackage

// File: rtl/cwl_sync.sv
// Plain flop chain for an asynchronous level; no reset on purpose.
module cwl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i) begin
    chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cwl_reset_sync.sv
// Asynchronous assert, clock-aligned release.
module cwl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= '0;
    else          stage_q <= stage_d;
  end

  assign rst_no = stage_q[STAGES-1];
endmodule

// File: rtl/cwl_mode_detect.sv
// Mode flop follows the strobe level while reset is held and freezes after.
module cwl_mode_detect
  import cwl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      strobe_lvl_i,
  output cfg_mode_e mode_o
);
  cfg_mode_e mode_q;
  cfg_mode_e mode_d;
  logic      sample_en;

  assign sample_en = ~rst_ni;

  always_comb begin
    mode_d = mode_q;
    if (sample_en) mode_d = cfg_mode_e'(strobe_lvl_i);
  end

  always_ff @(posedge clk_i) begin
    mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R1 / R9: mode frozen outside power-on reset
  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_q))
    else $error("mode changed outside power-on reset");
endmodule

// File: rtl/cwl_word_store.sv
// Edge detect on the synchronized strobe and the configuration word register.
module cwl_word_store
  import cwl_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_mode_e        mode_i,
  input  logic             hreset_act_i,
  input  logic             strobe_lvl_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  logic             prev_q, prev_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic             valid_q, valid_d;
  logic             strobe_rise;
  logic             load_en;

  assign strobe_rise = strobe_lvl_i & ~prev_q;
  assign load_en     = strobe_rise & hreset_act_i & (mode_i == CFG_EXTERNAL);

  always_comb begin
    prev_d  = strobe_lvl_i;
    word_d  = word_q;
    valid_d = valid_q;
    if (load_en) begin
      word_d  = data_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R3: a load stores the bus value seen in that cycle
  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> word_q == $past(data_i))
    else $error("captured word differs from bus");

  // R4 / R2: the word only moves inside the hard-reset window in external mode
  p_word_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_q) |-> ($past(hreset_act_i) && $past(mode_i) == CFG_EXTERNAL))
    else $error("word changed outside load window");

  // R6: valid is sticky until power-on reset
  p_valid_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q)
    else $error("valid dropped");
endmodule

// File: rtl/cfg_word_latch.sv
module cfg_word_latch
  import cwl_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             hreset_ni,
  input  logic             strobe_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] cfg_word_o,
  output logic             cfg_valid_o,
  output logic             cfg_ext_o
);
  logic      rst_n;
  logic      strobe_lvl;
  logic      hreset_lvl;
  logic      hreset_act;
  cfg_mode_e mode;

  cwl_reset_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (por_ni),
    .rst_no  (rst_n)
  );

  cwl_sync #(.STAGES(SYNC_STAGES)) i_strobe_sync (
    .clk_i   (clk_i),
    .async_i (strobe_ni),
    .sync_o  (strobe_lvl)
  );

  cwl_sync #(.STAGES(SYNC_STAGES)) i_hreset_sync (
    .clk_i   (clk_i),
    .async_i (hreset_ni),
    .sync_o  (hreset_lvl)
  );

  assign hreset_act = ~hreset_lvl;

  cwl_mode_detect i_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .strobe_lvl_i (strobe_lvl),
    .mode_o       (mode)
  );

  cwl_word_store #(.WIDTH(WIDTH)) i_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .hreset_act_i (hreset_act),
    .strobe_lvl_i (strobe_lvl),
    .data_i       (data_i),
    .word_o       (cfg_word_o),
    .valid_o      (cfg_valid_o)
  );

  assign cfg_ext_o = (mode == CFG_EXTERNAL);

  // R2: default mode always presents the all-zero word
  p_default_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_ext_o |-> (cfg_word_o == '0 && !cfg_valid_o))
    else $error("default mode with non-zero word");
endmodule

// File: tb/test_cfg_word_latch.sv
module test_cfg_word_latch;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        por_n, hreset_n, strobe_n;
  logic [31:0] data;
  logic [31:0] cfg_word;
  logic        cfg_valid, cfg_ext;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_word;
  logic [31:0] early_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_word_latch i_cfg_word_latch (
    .clk_i       (clk),
    .por_ni      (por_n),
    .hreset_ni   (hreset_n),
    .strobe_ni   (strobe_n),
    .data_i      (data),
    .cfg_word_o  (cfg_word),
    .cfg_valid_o (cfg_valid),
    .cfg_ext_o   (cfg_ext)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // power-on reset with a given strobe level; hard reset left asserted
  task automatic do_por(input logic lvl);
    @(negedge clk);
    strobe_n = lvl;
    hreset_n = 1'b0;
    por_n    = 1'b0;
    wait_neg(5);
    por_n = 1'b1;
    wait_neg(4);
  endtask

  // low pulse; leaves time at the third falling edge after the strobe rises
  task automatic pulse(input logic [31:0] d);
    data     = d;
    strobe_n = 1'b0;
    wait_neg(3);
    strobe_n = 1'b1;
    wait_neg(2);
    early_word = cfg_word;
    wait_neg(1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; hreset_n = 1'b0; strobe_n = 1'b1; data = '0;

    // external mode, nothing loaded yet
    do_por(1'b1);
    chk("R1 ext mode", {31'b0, cfg_ext}, 32'd1);
    chk("R5 word cleared", cfg_word, 32'h0);
    chk("R5 valid cleared", {31'b0, cfg_valid}, 32'd0);

    // latency: old word one edge early, new word when due
    pulse(32'hA5C3_0F96);
    chk("R3 not early", early_word, 32'h0);
    chk("R3 capture", cfg_word, 32'hA5C3_0F96);
    chk("R6 valid set", {31'b0, cfg_valid}, 32'd1);

    // walking ones and zeros, each overwriting the last
    for (int i = 0; i < 32; i++) begin
      exp_word = 32'h1 << i;
      pulse(exp_word);
      chk("R7 walk one", cfg_word, exp_word);
      exp_word = ~(32'h1 << i);
      pulse(exp_word);
      chk("R7 walk zero", cfg_word, exp_word);
    end
    for (int i = 1; i <= 16; i++) begin
      exp_word = i * 32'h9E37_79B9;
      pulse(exp_word);
      chk("R3 pattern", cfg_word, exp_word);
    end
    chk("R6 valid held", {31'b0, cfg_valid}, 32'd1);

    // outside hard reset: pulse ignored
    hreset_n = 1'b1;
    wait_neg(4);
    pulse(~exp_word);
    chk("R4 ignored outside window", cfg_word, exp_word);
    chk("R6 valid stays", {31'b0, cfg_valid}, 32'd1);

    // hard reset again keeps loaded word
    hreset_n = 1'b0;
    wait_neg(4);
    chk("R8 word kept in hard reset", cfg_word, exp_word);
    pulse(32'h0F0F_1234);
    chk("R7 reload new window", cfg_word, 32'h0F0F_1234);

    // power-on reset, strobe held high, no pulses
    do_por(1'b1);
    chk("R5 cleared again", cfg_word, 32'h0);
    hreset_n = 1'b1;
    wait_neg(20);
    chk("R5 tied high stays zero", cfg_word, 32'h0);
    chk("R5 tied high no valid", {31'b0, cfg_valid}, 32'd0);

    // default mode
    do_por(1'b0);
    chk("R9 switch to default", {31'b0, cfg_ext}, 32'd0);
    chk("R1 default mode", {31'b0, cfg_ext}, 32'd0);
    strobe_n = 1'b1;
    wait_neg(4);
    pulse(32'hFFFF_FFFF);
    chk("R2 default word zero", cfg_word, 32'h0);
    chk("R2 default no valid", {31'b0, cfg_valid}, 32'd0);

    // back to external
    do_por(1'b1);
    chk("R9 switch to ext", {31'b0, cfg_ext}, 32'd1);
    pulse(32'h1357_9BDF);
    chk("R3 after re-arm", cfg_word, 32'h1357_9BDF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule